// File: doc/BRIEF.md
# Calendar Timekeeping Counter Core

This block keeps wall-clock time and a calendar. It counts seconds, minutes, hours, day of week, date, month, two-digit year and a century byte, and it advances once on each one-cycle pulse of `tick_1hz`. Every field is stored as a byte. `bin_mode` selects how the counting logic reads those bytes: as plain binary or as two BCD digits. `h12_mode` selects 24-hour counting or 12-hour counting, where bit 7 of the hour byte marks PM.

Software reads and writes all fields through a byte-addressed port. The read data is combinational and the write is synchronous. Three alarm bytes hold a target second, minute and hour. When a tick moves the time onto those values, a one-cycle strobe fires. A status byte reports the cycle in which the counters are about to change, so software can skip reading a value that is only partly updated.

Top module: `cal_core`

## Requirements
- R1: Seconds and minutes count 0 to 59. A tick at 59 returns the field to 0 and advances the next field. Below 59 a tick adds exactly one.
- R2: With `bin_mode`=1, fields are binary: seconds 0x3B rolls to 0x00. With `bin_mode`=0, fields are BCD: 0x09 steps to 0x10 and 0x59 rolls to 0x00.
- R3: With `h12_mode`=0, hours count 0 to 23: 0x17 in binary and 0x23 in BCD. Hour 23 rolls to 0 and advances day of week and date.
- R4: With `h12_mode`=1, hours run 1 to 12 with bit 7 set for PM. Hour 11 steps to 12 and flips bit 7. Hour 12 steps to 1 and keeps bit 7. 11 PM (0x91 BCD, 0x8B binary) steps to 12 AM (0x12, 0x0C) and advances the date.
- R5: Day of week counts 1 to 7, and a day carry at 7 gives 1.
- R6: Months 4, 6, 9 and 11 end at 30. Month 2 ends at 29 when the year is divisible by 4 (year 0 included) and at 28 otherwise. The remaining months end at 31. A day carry on the last date gives date 1 and advances the month.
- R7: Month 12 rolls to 1 and advances the year. Year 99 rolls to 0 and adds one to the century in the selected encoding. Century 99 rolls to 0.
- R8: The register map is as follows. Address 0 holds seconds, 2 minutes, 4 hours, 6 day of week, 7 date, 8 month and 9 year. Addresses 1, 3 and 5 hold the second, minute and hour alarms. Address 50 holds the century. Address 10 is status: bit 7 reads 1 in the cycle after a tick is sampled (the cycle in which the counters update) and 0 otherwise, and its other bits read 0.
- R9: `alarm_o` is high for exactly one cycle, the cycle after the counters update, when the updated seconds, minutes and hours all equal their alarm bytes. It stays low when any of them differs.
- R10: A write in the update cycle wins for the field it addresses. The other fields still advance. The alarm compare uses the written value.
- R11: Without a tick, time fields keep their values; writes to other addresses do not disturb them.
- R12: After reset the fields read as follows: seconds, minutes, hours, year and century 0; day of week, date and month 1; alarms 0; status 0; `alarm_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse that advances time by one second |
| bin_mode | input | 1 | 1 selects binary fields, 0 selects BCD fields |
| h12_mode | input | 1 | 1 selects 12-hour counting with PM in bit 7 |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | ADDR_W | Register byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data at `addr` |
| alarm_o | output | 1 | One-cycle alarm strobe |

## Verification
A software write and the tick update can land on the same clock edge, and the alarm compare is evaluated on that same edge. The bench starts a tick and then drives a minute write in the update cycle, with the alarm set to the time that only the written minute can produce. The result is correct only when all three hold: the minute shows the written value, the seconds have still advanced, and `alarm_o` rises in the following cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;

   // Byte value to number, binary or two BCD digits
   function automatic logic [6:0] enc_to_num(input logic [7:0] v, input logic bin);
      if (bin) return v[6:0];
      return 7'(32'(v[7:4]) * 10 + 32'(v[3:0]));
   endfunction

   // Number (0..99) to byte value in the selected encoding
   function automatic logic [7:0] num_to_enc(input logic [6:0] n, input logic bin);
      if (bin) return {1'b0, n};
      return {4'(n / 7'd10), 4'(n % 7'd10)};
   endfunction

endpackage

// File: rtl/cal_field_ctr.sv
module cal_field_ctr
   import cal_pkg::*;
(
   input  logic [7:0] cur,
   input  logic       bin,
   input  logic [6:0] lo,
   input  logic [6:0] hi,
   output logic [7:0] nxt,
   output logic       at_top
);
   logic [6:0] num;

   always_comb begin
      num    = enc_to_num(cur, bin);
      at_top = (num >= hi);
      nxt    = at_top ? num_to_enc(lo, bin) : num_to_enc(7'(num + 7'd1), bin);
   end
endmodule

// File: rtl/cal_hour_ctr.sv
module cal_hour_ctr
   import cal_pkg::*;
(
   input  logic [7:0] cur,
   input  logic       bin,
   input  logic       h12,
   output logic [7:0] nxt,
   output logic       day_carry
);
   logic       pm;
   logic [6:0] n;
   logic [7:0] e12, e1, einc;

   always_comb begin
      pm   = cur[7];
      n    = h12 ? enc_to_num({1'b0, cur[6:0]}, bin) : enc_to_num(cur, bin);
      e12  = num_to_enc(7'd12, bin);
      e1   = num_to_enc(7'd1, bin);
      einc = num_to_enc(7'(n + 7'd1), bin);
      if (h12) begin
         if (n == 7'd11) begin
            nxt       = {~pm, e12[6:0]};
            day_carry = pm;
         end else if (n >= 7'd12) begin
            nxt       = {pm, e1[6:0]};
            day_carry = 1'b0;
         end else begin
            nxt       = {pm, einc[6:0]};
            day_carry = 1'b0;
         end
      end else begin
         day_carry = (n >= 7'd23);
         nxt       = day_carry ? num_to_enc(7'd0, bin) : einc;
      end
   end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
   import cal_pkg::*;
(
   input  logic [7:0] month,
   input  logic [7:0] year,
   input  logic       bin,
   output logic [6:0] last_day
);
   logic [6:0] m, y;

   always_comb begin
      m = enc_to_num(month, bin);
      y = enc_to_num(year, bin);
      case (m)
         7'd2:                    last_day = (y[1:0] == 2'b00) ? 7'd29 : 7'd28;
         7'd4, 7'd6, 7'd9, 7'd11: last_day = 7'd30;
         default:                 last_day = 7'd31;
      endcase
   end
endmodule

// File: rtl/cal_core.sv
module cal_core
   import cal_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int STAT_ADDR = 10,
   parameter int CENT_ADDR = 50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              bin_mode,
   input  logic              h12_mode,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              alarm_o
);
   // Field slots: 0 sec, 1 min, 2 day of week, 3 date, 4 month, 5 year, 6 century
   localparam int NF = 7;
   localparam int F_SEC = 0, F_MIN = 1, F_DOW = 2, F_DATE = 3, F_MON = 4, F_YR = 5, F_CENT = 6;
   localparam int FLD_ADDR [NF] = '{0, 2, 6, 7, 8, 9, CENT_ADDR};
   localparam logic [7:0] RST_VAL [NF] = '{8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
   localparam int A_HR = 4, A_ALS = 1, A_ALM = 3, A_ALH = 5;

   if (DATA_W != 8) begin : g_bad_width
      $error("cal_core: DATA_W must be 8");
   end
   if (CENT_ADDR >= (1 << ADDR_W) || STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("cal_core: address parameter outside ADDR_W range");
   end
   if (CENT_ADDR <= 9 || STAT_ADDR <= 9 || CENT_ADDR == STAT_ADDR) begin : g_bad_map
      $error("cal_core: status/century addresses collide with time fields");
   end

   logic [7:0] fld_q [NF];
   logic [7:0] fld_d [NF];
   logic [7:0] fld_nxt [NF];
   logic       fld_top [NF];
   logic       fld_adv [NF];
   logic       fld_wr  [NF];
   logic [6:0] lo_v [NF];
   logic [6:0] hi_v [NF];
   logic [6:0] mlen;
   logic [7:0] hr_q, hr_d, hr_nxt;
   logic       hr_carry, hr_adv, day_adv, hr_wr;
   logic [7:0] al_s, al_m, al_h;
   logic       upd_q;

   cal_month_len u_mlen (
      .month(fld_q[F_MON]), .year(fld_q[F_YR]), .bin(bin_mode), .last_day(mlen)
   );

   cal_hour_ctr u_hour (
      .cur(hr_q), .bin(bin_mode), .h12(h12_mode), .nxt(hr_nxt), .day_carry(hr_carry)
   );

   always_comb begin
      lo_v = '{7'd0, 7'd0, 7'd1, 7'd1, 7'd1, 7'd0, 7'd0};
      hi_v = '{7'd59, 7'd59, 7'd7, mlen, 7'd12, 7'd99, 7'd99};
   end

   for (genvar i = 0; i < NF; i++) begin : g_fld
      cal_field_ctr u_ctr (
         .cur(fld_q[i]), .bin(bin_mode), .lo(lo_v[i]), .hi(hi_v[i]),
         .nxt(fld_nxt[i]), .at_top(fld_top[i])
      );
      assign fld_wr[i] = wr_en && (addr == ADDR_W'(FLD_ADDR[i]));
      assign fld_d[i]  = fld_wr[i] ? wdata : (fld_adv[i] ? fld_nxt[i] : fld_q[i]);
   end

   // Carry chain, from seconds up to century
   always_comb begin
      fld_adv[F_SEC]  = upd_q;
      fld_adv[F_MIN]  = upd_q && fld_top[F_SEC];
      hr_adv          = fld_adv[F_MIN] && fld_top[F_MIN];
      day_adv         = hr_adv && hr_carry;
      fld_adv[F_DOW]  = day_adv;
      fld_adv[F_DATE] = day_adv;
      fld_adv[F_MON]  = day_adv && fld_top[F_DATE];
      fld_adv[F_YR]   = fld_adv[F_MON] && fld_top[F_MON];
      fld_adv[F_CENT] = fld_adv[F_YR] && fld_top[F_YR];
   end

   assign hr_wr = wr_en && (addr == ADDR_W'(A_HR));
   assign hr_d  = hr_wr ? wdata : (hr_adv ? hr_nxt : hr_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NF; i++) fld_q[i] <= RST_VAL[i];
         hr_q    <= '0;
         al_s    <= '0;
         al_m    <= '0;
         al_h    <= '0;
         upd_q   <= 1'b0;
         alarm_o <= 1'b0;
      end else begin
         for (int i = 0; i < NF; i++) fld_q[i] <= fld_d[i];
         hr_q  <= hr_d;
         upd_q <= tick_1hz;
         if (wr_en && addr == ADDR_W'(A_ALS)) al_s <= wdata;
         if (wr_en && addr == ADDR_W'(A_ALM)) al_m <= wdata;
         if (wr_en && addr == ADDR_W'(A_ALH)) al_h <= wdata;
         alarm_o <= upd_q && (fld_d[F_SEC] == al_s) && (fld_d[F_MIN] == al_m) && (hr_d == al_h);
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NF; i++)
         if (addr == ADDR_W'(FLD_ADDR[i])) rdata = fld_q[i];
      if (addr == ADDR_W'(A_HR))      rdata = hr_q;
      if (addr == ADDR_W'(A_ALS))     rdata = al_s;
      if (addr == ADDR_W'(A_ALM))     rdata = al_m;
      if (addr == ADDR_W'(A_ALH))     rdata = al_h;
      if (addr == ADDR_W'(STAT_ADDR)) rdata = {upd_q, 7'd0};
   end

   // R8: update flag only follows a sampled tick
   p_flag_follows_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |-> $past(tick_1hz));

   // R9: alarm strobe only right after an update cycle
   p_alarm_after_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_o |-> $past(upd_q));

   // R11: no tick, no write -> time stays put
   p_hold_between_ticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_q && !wr_en) |=> ($stable(fld_q[F_SEC]) && $stable(fld_q[F_MIN]) &&
                              $stable(hr_q) && $stable(fld_q[F_DATE]) && $stable(fld_q[F_CENT])));

   // R1: seconds below 59 step by exactly one on an update
   p_sec_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_q && !wr_en && enc_to_num(fld_q[F_SEC], bin_mode) < 7'd59) |=>
      ((bin_mode != $past(bin_mode)) ||
       (32'(enc_to_num(fld_q[F_SEC], bin_mode)) == 32'($past(enc_to_num(fld_q[F_SEC], bin_mode))) + 1)));
endmodule

// File: tb/cal_core_tb.sv
module cal_core_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_1hz = 1'b0;
   logic          bin_mode = 1'b0;
   logic          h12_mode = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          alarm_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   cal_core dut_i (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bin_mode(bin_mode),
      .h12_mode(h12_mode), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .alarm_o(alarm_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      addr = AW'(a);
      #1;
      d = rdata;
   endtask

   task automatic expect_reg(input string req, input int a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, $sformatf("addr %0d", a), v, exp);
   endtask

   // ends just after the negedge following the update edge
   task automatic tick_pulse();
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
      wr(4, h); wr(2, m); wr(0, s);
   endtask

   task automatic t_reset();
      expect_reg("R12", 0, 8'h00); expect_reg("R12", 2, 8'h00); expect_reg("R12", 4, 8'h00);
      expect_reg("R12", 6, 8'h01); expect_reg("R12", 7, 8'h01); expect_reg("R12", 8, 8'h01);
      expect_reg("R12", 9, 8'h00); expect_reg("R12", 50, 8'h00); expect_reg("R12", 5, 8'h00);
      expect_reg("R12", 10, 8'h00);
      chk("R12", "alarm_o", {7'd0, alarm_o}, 8'h00);
   endtask

   task automatic t_bcd_seconds();
      bin_mode = 1'b0; h12_mode = 1'b0;
      wr(0, 8'h08); tick_pulse(); expect_reg("R1", 0, 8'h09);
      tick_pulse(); expect_reg("R2", 0, 8'h10);
      wr(2, 8'h07); wr(0, 8'h59); tick_pulse();
      expect_reg("R2", 0, 8'h00); expect_reg("R1", 2, 8'h08);
   endtask

   task automatic t_binary_rollover();
      bin_mode = 1'b1; h12_mode = 1'b0;
      set_hms(8'h17, 8'h3B, 8'h3B);
      wr(6, 8'h07); wr(7, 8'h1F); wr(8, 8'h0C); wr(9, 8'h63); wr(50, 8'h13);
      tick_pulse();
      expect_reg("R2", 0, 8'h00); expect_reg("R1", 2, 8'h00); expect_reg("R3", 4, 8'h00);
      expect_reg("R5", 6, 8'h01); expect_reg("R6", 7, 8'h01); expect_reg("R7", 8, 8'h01);
      expect_reg("R7", 9, 8'h00); expect_reg("R7", 50, 8'h14);
   endtask

   task automatic t_bcd_century();
      bin_mode = 1'b0; h12_mode = 1'b0;
      set_hms(8'h23, 8'h59, 8'h59);
      wr(6, 8'h03); wr(7, 8'h31); wr(8, 8'h12); wr(9, 8'h99); wr(50, 8'h99);
      tick_pulse();
      expect_reg("R3", 4, 8'h00); expect_reg("R5", 6, 8'h04);
      expect_reg("R7", 9, 8'h00); expect_reg("R7", 50, 8'h00);
      // century carry in BCD from 19 to 20
      set_hms(8'h23, 8'h59, 8'h59);
      wr(7, 8'h31); wr(8, 8'h12); wr(9, 8'h99); wr(50, 8'h19);
      tick_pulse();
      expect_reg("R7", 50, 8'h20);
   endtask

   task automatic roll_day(input logic [7:0] mon, input logic [7:0] yr, input logic [7:0] dt,
                           input logic [7:0] exp_dt, input logic [7:0] exp_mon);
      set_hms(8'h23, 8'h59, 8'h59);
      wr(7, dt); wr(8, mon); wr(9, yr);
      tick_pulse();
      expect_reg("R6", 7, exp_dt); expect_reg("R6", 8, exp_mon);
   endtask

   task automatic t_month_len();
      bin_mode = 1'b0; h12_mode = 1'b0;
      roll_day(8'h02, 8'h24, 8'h28, 8'h29, 8'h02);
      roll_day(8'h02, 8'h24, 8'h29, 8'h01, 8'h03);
      roll_day(8'h02, 8'h23, 8'h28, 8'h01, 8'h03);
      roll_day(8'h02, 8'h00, 8'h28, 8'h29, 8'h02);
      roll_day(8'h04, 8'h23, 8'h30, 8'h01, 8'h05);
      roll_day(8'h01, 8'h23, 8'h30, 8'h31, 8'h01);
   endtask

   task automatic t_12h();
      bin_mode = 1'b0; h12_mode = 1'b1;
      set_hms(8'h11, 8'h59, 8'h59); tick_pulse(); expect_reg("R4", 4, 8'h92);
      set_hms(8'h92, 8'h59, 8'h59); tick_pulse(); expect_reg("R4", 4, 8'h81);
      set_hms(8'h12, 8'h59, 8'h59); tick_pulse(); expect_reg("R4", 4, 8'h01);
      wr(7, 8'h05); set_hms(8'h91, 8'h59, 8'h59); tick_pulse();
      expect_reg("R4", 4, 8'h12); expect_reg("R4", 7, 8'h06);
      bin_mode = 1'b1;
      wr(7, 8'h05); set_hms(8'h8B, 8'h3B, 8'h3B); tick_pulse();
      expect_reg("R4", 4, 8'h0C); expect_reg("R4", 7, 8'h06);
      h12_mode = 1'b0;
   endtask

   task automatic t_flag_map();
      logic [7:0] v;
      bin_mode = 1'b0;
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      rd(10, v); chk("R8", "status during update", v, 8'h80);
      @(negedge clk);
      rd(10, v); chk("R8", "status after update", v, 8'h00);
      wr(1, 8'h45); wr(3, 8'h12); wr(5, 8'h07); wr(50, 8'h21);
      expect_reg("R8", 1, 8'h45); expect_reg("R8", 3, 8'h12);
      expect_reg("R8", 5, 8'h07); expect_reg("R8", 50, 8'h21);
   endtask

   task automatic t_alarm();
      bin_mode = 1'b0; h12_mode = 1'b0;
      wr(5, 8'h10); wr(3, 8'h20); wr(1, 8'h30);
      set_hms(8'h10, 8'h20, 8'h29);
      chk("R9", "alarm idle", {7'd0, alarm_o}, 8'h00);
      tick_pulse();
      chk("R9", "alarm on match", {7'd0, alarm_o}, 8'h01);
      @(negedge clk);
      chk("R9", "alarm one cycle", {7'd0, alarm_o}, 8'h00);
      set_hms(8'h10, 8'h21, 8'h29);
      tick_pulse();
      chk("R9", "alarm minute mismatch", {7'd0, alarm_o}, 8'h00);
   endtask

   task automatic t_collision();
      bin_mode = 1'b0; h12_mode = 1'b0;
      wr(5, 8'h05); wr(3, 8'h33); wr(1, 8'h10);
      set_hms(8'h05, 8'h07, 8'h09);
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
      wr_en = 1'b1; addr = AW'(2); wdata = 8'h33;
      @(negedge clk); wr_en = 1'b0;
      chk("R10", "alarm with written minute", {7'd0, alarm_o}, 8'h01);
      expect_reg("R10", 2, 8'h33); expect_reg("R10", 0, 8'h10);
   endtask

   task automatic t_hold();
      logic [7:0] s0;
      bin_mode = 1'b0;
      wr(0, 8'h42);
      rd(0, s0);
      wr(1, 8'h11); wr(50, 8'h20);
      repeat (6) @(negedge clk);
      expect_reg("R11", 0, s0); expect_reg("R11", 0, 8'h42);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bcd_seconds();
      t_binary_rollover();
      t_bcd_century();
      t_month_len();
      t_12h();
      t_flag_map();
      t_alarm();
      t_collision();
      t_hold();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule